// File: doc/BRIEF.md
# Keyed Write Guard for an Output Data Register

This block protects a small output-data register from accidental writes. The host reaches it over a simple register bus: an address, a one-cycle write strobe and an 8-bit write byte. After reset the data register is locked, and the block drops every write aimed at it. To open the lock, software writes four magic bytes, in a fixed order, to a single key address. After the last byte lands, writes to the data register take effect and its value drives the output pins. Writing a separate exit byte to the key address closes the lock again.

The unlock tracker ignores traffic to other addresses. Software can therefore program unrelated registers between key bytes without losing its place in the sequence. A read port returns the lock state at the key address and the stored value at the data address.

Top module: `seqkey_guard`

## Requirements
- R1: After reset the block is locked (`unlocked_o` = 0), `data_out_o` is 0, and reads of the key address (0x32) and the data address (0x36) return 0x00.
- R2: While locked, a write to the data address (0x36) leaves `data_out_o` unchanged.
- R3: Writing 0x32, 0x5D, 0x42, 0xAC to address 0x32, in that order, raises `unlocked_o` on the clock edge that accepts the last byte. From then on, reading address 0x32 returns 0x01 (bit 0 is the lock-open flag, all other bits 0).
- R4: While unlocked, a write to 0x36 loads bits 5:0 of the byte into `data_out_o` at that clock edge. Reading 0x36 returns the stored value with bits 7:6 as 0. This holds for a write in the cycle right after the final key byte.
- R5: While locked, a key-address write that does not match the next expected byte restarts the sequence. The exception is the byte 0x32, which is counted as the first key byte.
- R6: Writes to addresses other than 0x32 neither advance nor restart a sequence in progress.
- R7: While unlocked, writing 0x35 to 0x32 relocks the block at that edge. A data write in the very next cycle is ignored.
- R8: While unlocked, key-address writes of any byte other than 0x35 keep the block unlocked.
- R9: A sequence that is incomplete or out of order never unlocks the block, and 0x35 written while locked has no unlocking effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| addr_i | input | 8 | Write address |
| wdata_i | input | 8 | Write byte |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Read data, combinational from `rd_addr_i` |
| data_out_o | output | 6 | Protected register value driven to pins |
| unlocked_o | output | 1 | 1 while writes to the data register are allowed |

## Verification
A change of lock state and a gated data write can land on adjacent clock edges. The final key byte or the exit byte commits on one edge, and a data write presented in the very next cycle is judged against the new state. The bench provokes both orders back to back, with no idle cycle between them. A data write right after the last key byte must appear on `data_out_o`. A data write right after the exit byte must leave the pins unchanged.

// File: rtl/seqkey_pkg.sv
package seqkey_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned KEY_LEN = 4;

    // Ordered unlock bytes; position sets the order of acceptance.
    function automatic logic [BYTE_W-1:0] key_byte(input int unsigned idx);
        logic [BYTE_W-1:0] b;
        case (idx)
            0:       b = 8'h32;
            1:       b = 8'h5D;
            2:       b = 8'h42;
            default: b = 8'hAC;
        endcase
        return b;
    endfunction

    localparam logic [BYTE_W-1:0] EXIT_BYTE = 8'h35;

endpackage

// File: rtl/seqkey_tracker.sv
module seqkey_tracker
    import seqkey_pkg::*;
#(
    parameter int unsigned STG_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              key_wr_i,
    input  logic [BYTE_W-1:0] key_byte_i,
    output logic [STG_W-1:0]  stage_o,
    output logic              open_o
);
    localparam logic [STG_W-1:0] OPEN_STG = STG_W'(KEY_LEN);

    typedef struct packed {
        logic [STG_W-1:0] stage;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (key_wr_i) begin
            if (trk_q.stage == OPEN_STG) begin
                if (key_byte_i == EXIT_BYTE) trk_d.stage = '0;
            end else if (key_byte_i == key_byte(int'(trk_q.stage))) begin
                trk_d.stage = trk_q.stage + 1'b1;
            end else if (key_byte_i == key_byte(0)) begin
                trk_d.stage = STG_W'(1);
            end else begin
                trk_d.stage = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) trk_q <= '0;
        else         trk_q <= trk_d;
    end

    assign stage_o = trk_q.stage;
    assign open_o  = (trk_q.stage == OPEN_STG);
endmodule

// File: rtl/seqkey_datareg.sv
module seqkey_datareg #(
    parameter int unsigned DATA_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic              open_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] value_o
);
    typedef struct packed {
        logic [DATA_W-1:0] value;
    } dreg_t;

    dreg_t dreg_d, dreg_q;

    always_comb begin
        dreg_d = dreg_q;
        if (wr_i && open_i) dreg_d.value = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dreg_q <= '0;
        else         dreg_q <= dreg_d;
    end

    assign value_o = dreg_q.value;
endmodule

// File: rtl/seqkey_readmux.sv
module seqkey_readmux #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 6,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h32,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h36
) (
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              open_i,
    input  logic [DATA_W-1:0] value_i,
    output logic [7:0]        rd_data_o
);
    localparam int unsigned PAD_W = 8 - DATA_W;

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == KEY_ADDR)       rd_data_o = {7'b0, open_i};
        else if (rd_addr_i == DATA_ADDR) rd_data_o = {{PAD_W{1'b0}}, value_i};
    end
endmodule

// File: rtl/seqkey_guard.sv
module seqkey_guard
    import seqkey_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 6,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h32,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h36
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic [DATA_W-1:0] data_out_o,
    output logic              unlocked_o
);
    localparam int unsigned STG_W = $clog2(KEY_LEN + 1);

    logic             key_wr, data_wr, open;
    logic [STG_W-1:0] stage_q;

    assign key_wr  = wr_en_i && (addr_i == KEY_ADDR);
    assign data_wr = wr_en_i && (addr_i == DATA_ADDR);

    seqkey_tracker #(.STG_W(STG_W)) trk_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .key_wr_i(key_wr),
        .key_byte_i(wdata_i), .stage_o(stage_q), .open_o(open)
    );

    seqkey_datareg #(.DATA_W(DATA_W)) dreg_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(data_wr), .open_i(open),
        .wdata_i(wdata_i[DATA_W-1:0]), .value_o(data_out_o)
    );

    seqkey_readmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                     .KEY_ADDR(KEY_ADDR), .DATA_ADDR(DATA_ADDR)) rmux_i (
        .rd_addr_i(rd_addr_i), .open_i(open), .value_i(data_out_o),
        .rd_data_o(rd_data_o)
    );

    assign unlocked_o = open;
endmodule

// File: rtl/seqkey_guard_chk.sv
module seqkey_guard_chk #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 6,
    parameter int unsigned STG_W     = 3,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h32,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h36
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [7:0]        wdata_i,
    input logic [DATA_W-1:0] data_out_o,
    input logic              unlocked_o,
    input logic [STG_W-1:0]  stage_q
);
    assert_locked_write_dropped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!unlocked_o && wr_en_i && addr_i == DATA_ADDR) |=> $stable(data_out_o));

    assert_open_write_loads_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (unlocked_o && wr_en_i && addr_i == DATA_ADDR) |=> data_out_o == $past(wdata_i[DATA_W-1:0]));

    assert_last_key_opens_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!unlocked_o && stage_q == STG_W'(3) && wr_en_i && addr_i == KEY_ADDR && wdata_i == 8'hAC)
        |=> unlocked_o);

    assert_open_needs_last_key_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(unlocked_o) |-> ($past(wdata_i) == 8'hAC && $past(addr_i) == KEY_ADDR && $past(wr_en_i)));

    assert_other_addr_no_effect_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && addr_i == KEY_ADDR) |=> $stable(stage_q));

    assert_exit_relocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (unlocked_o && wr_en_i && addr_i == KEY_ADDR && wdata_i == 8'h35) |=> !unlocked_o);

    assert_stays_open_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (unlocked_o && !(wr_en_i && addr_i == KEY_ADDR && wdata_i == 8'h35)) |=> unlocked_o);
endmodule

bind seqkey_guard seqkey_guard_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STG_W(STG_W),
    .KEY_ADDR(KEY_ADDR), .DATA_ADDR(DATA_ADDR)
) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .data_out_o(data_out_o), .unlocked_o(unlocked_o),
    .stage_q(stage_q)
);

// File: tb/seqkey_guard_tb.sv
module seqkey_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] KA = 8'h32;
    localparam logic [7:0] DA = 8'h36;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = '0, wdata = '0, rd_addr = '0;
    logic [7:0] rd_data;
    logic [5:0] data_out;
    logic       unlocked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seqkey_guard dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .data_out_o(data_out), .unlocked_o(unlocked)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One-cycle write, driven at a falling edge; returns at the next falling edge.
    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic send_keys();
        bus_wr(KA, 8'h32); bus_wr(KA, 8'h5D); bus_wr(KA, 8'h42); bus_wr(KA, 8'hAC);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [7:0] r;
        do_reset();
        check(unlocked == 1'b0, "R1 unlocked", unlocked, 0);
        check(data_out == 6'd0, "R1 data_out", data_out, 0);
        bus_rd(KA, r); check(r == 8'h00, "R1 key read", r, 0);
        bus_rd(DA, r); check(r == 8'h00, "R1 data read", r, 0);
    endtask

    task automatic t_locked_write();
        bus_wr(DA, 8'h2A);
        check(data_out == 6'd0, "R2 locked write", data_out, 0);
    endtask

    task automatic t_unlock_and_write();
        logic [7:0] r;
        send_keys();
        bus_wr(DA, 8'hFF);   // adjacent cycle after last key
        check(unlocked == 1'b1, "R3 unlocked", unlocked, 1);
        bus_rd(KA, r); check(r == 8'h01, "R3 key read", r, 1);
        check(data_out == 6'h3F, "R4 adjacent write", data_out, 6'h3F);
        bus_rd(DA, r); check(r == 8'h3F, "R4 read high bits zero", r, 8'h3F);
        bus_wr(DA, 8'h15);
        check(data_out == 6'h15, "R4 second write", data_out, 6'h15);
    endtask

    task automatic t_stay_unlocked();
        bus_wr(KA, 8'h00); bus_wr(KA, 8'hAC); bus_wr(KA, 8'h32);
        check(unlocked == 1'b1, "R8 stays open", unlocked, 1);
    endtask

    task automatic t_exit();
        bus_wr(KA, 8'h35);
        bus_wr(DA, 8'h0C);   // adjacent cycle after exit
        check(unlocked == 1'b0, "R7 relocked", unlocked, 0);
        check(data_out == 6'h15, "R7 write after exit", data_out, 6'h15);
    endtask

    task automatic t_wrong_byte();
        bus_wr(KA, 8'h32); bus_wr(KA, 8'h5D); bus_wr(KA, 8'h99);
        bus_wr(KA, 8'h42); bus_wr(KA, 8'hAC);
        check(unlocked == 1'b0, "R5 mismatch restarts", unlocked, 0);
        bus_wr(KA, 8'h32); bus_wr(KA, 8'h32); bus_wr(KA, 8'h5D);
        bus_wr(KA, 8'h42); bus_wr(KA, 8'hAC);
        check(unlocked == 1'b1, "R5 repeated first byte", unlocked, 1);
        bus_wr(KA, 8'h35);
    endtask

    task automatic t_interleave();
        bus_wr(KA, 8'h32); bus_wr(8'h10, 8'h00); bus_wr(KA, 8'h5D);
        bus_wr(DA, 8'h01); bus_wr(KA, 8'h42); bus_wr(8'h33, 8'h99);
        check(unlocked == 1'b0, "R6 not yet open", unlocked, 0);
        bus_wr(KA, 8'hAC);
        check(unlocked == 1'b1, "R6 interleaved unlock", unlocked, 1);
        check(data_out == 6'h15, "R6 locked data write dropped", data_out, 6'h15);
        bus_wr(KA, 8'h35);
    endtask

    task automatic t_partial();
        bus_wr(KA, 8'h35);
        check(unlocked == 1'b0, "R9 exit while locked", unlocked, 0);
        bus_wr(KA, 8'h5D); bus_wr(KA, 8'h42); bus_wr(KA, 8'hAC);
        check(unlocked == 1'b0, "R9 missing first", unlocked, 0);
        bus_wr(KA, 8'h32); bus_wr(KA, 8'h42); bus_wr(KA, 8'h5D); bus_wr(KA, 8'hAC);
        check(unlocked == 1'b0, "R9 swapped order", unlocked, 0);
        bus_wr(KA, 8'h32); bus_wr(KA, 8'h5D); bus_wr(KA, 8'h42);
        check(unlocked == 1'b0, "R9 three of four", unlocked, 0);
        bus_wr(KA, 8'h35);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_locked_write();
        t_unlock_and_write();
        t_stay_unlocked();
        t_exit();
        t_wrong_byte();
        t_interleave();
        t_partial();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule